// File: doc/BRIEF.md
# Vector Memory Address Generator and Burst Coalescer

This block sits between a vector unit's instruction sequencing and a single wide memory port. It accepts one vector memory command at a time (base address, element width, vector length, access mode, store flag, and a stride) and turns it into a stream of transaction requests. Each request carries a start address, a beat count and a transfer size. Requests go to a load engine or a store engine, which are outside this block and drive an AXI-style port.

Contiguous accesses are merged into multi-beat bursts. The port is `4 * LANES` bytes wide, which keeps bandwidth at two bytes per double-precision FLOP when each lane does one fused multiply-add per cycle. Bursts are cut at every 4 KiB page edge and at 256 beats. Strided accesses send one single-beat request per element. So do indexed accesses, which take one byte offset per element from a separate offset stream. A single registered output stage holds each request until the selected engine accepts it.

Top module: `vmem_addr_coalescer`

## Requirements
- R1: With `cmd_mode` = 0 (unit stride), the bursts cover every bus beat that overlaps the byte range [base, base + vl·2^ew) and no other beat. The first burst starts at the base address. Each later burst starts at a beat-aligned address. Every burst uses size = log2(bus bytes). Bursts come out in increasing address order.
- R2: No unit-stride burst crosses a 4 KiB boundary. The beat-aligned start offset within the page, plus (len+1) beats, never exceeds 4096 bytes.
- R3: No burst is longer than 256 beats. The len field is beats minus one, and a longer run is split.
- R4: With `cmd_mode` = 1 (constant stride), element i gets one request at base + i·stride, with len = 0 and size = ew. The stride is a two's-complement byte offset, and addresses wrap modulo 2^AW. Requests come out in increasing i. Element widths are 1, 2, 4 or 8 bytes for ew = 0..3.
- R5: With `cmd_mode` = 2 or 3 (indexed), element i gets one request at base + offset_i, with len = 0 and size = ew. Offsets are taken in order, one per accepted offset-stream handshake, and exactly vl offsets are consumed.
- R6: Requests for a command with `cmd_store` = 1 appear only on the store port. All others appear only on the load port. The two ports are never valid together.
- R7: A request not yet accepted keeps its valid, address, length and size unchanged in the next cycle.
- R8: `cmd_ready` is high only when the previous command is fully issued and accepted. While it is high, no request is valid. A command with vl = 0 produces no request.
- R9: After reset, both request ports are idle and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_base | input | AW | Base byte address |
| cmd_ew | input | 2 | log2 of element bytes |
| cmd_vl | input | VL_W | Element count |
| cmd_mode | input | 2 | 0 unit stride, 1 constant stride, 2/3 indexed |
| cmd_stride | input | AW | Byte stride, two's complement |
| cmd_store | input | 1 | 1 routes requests to the store port |
| idx_valid | input | 1 | Offset available |
| idx_ready | output | 1 | Offset consumed this cycle when valid |
| idx_off | input | AW | Per-element byte offset |
| ld_valid | output | 1 | Load request valid |
| ld_ready | input | 1 | Load engine accepts |
| ld_addr | output | AW | Load start address |
| ld_len | output | 8 | Load beats minus one |
| ld_size | output | 3 | log2 bytes per beat |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store engine accepts |
| st_addr | output | AW | Store start address |
| st_len | output | 8 | Store beats minus one |
| st_size | output | 3 | log2 bytes per beat |

## Verification
The bench targets several corner cases. One is an unaligned base, where a design that counted beats from the raw byte count would drop the final partial beat. Another is a range that ends just past a page edge, where a missing split would produce a burst that runs into the next page. A third is a 600-element run starting on a page, where the 256-beat cap must be hit twice before the page edge. Further tests cover negative and zero strides, and indexed accesses with gaps in the offset stream, where a design that ran ahead of the offsets would emit stale addresses. Random backpressure on both engines exposes any request that changes or vanishes before acceptance. A zero-length command exposes a design that emits a spurious request.

// File: rtl/vmem_pkg.sv
`timescale 1ns/1ps
package vmem_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2
  } amode_e;

  localparam int PAGE_LG   = 12;   // 4 KiB page
  localparam int MAX_BURST = 256;  // beats per burst
  localparam int LEN_W     = 8;
  localparam int SIZE_W    = 3;
endpackage

// File: rtl/vmem_burst_planner.sv
`timescale 1ns/1ps
// Combinational beat count for the next unit-stride burst: the smallest of
// the beats left, the beats to the page edge, and the burst cap.
module vmem_burst_planner #(
  parameter int AW    = 32,
  parameter int BB_LG = 3,
  parameter int CW    = 15
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [CW-1:0] rem_beats,
  output logic [CW-1:0] beats,
  output logic [AW-1:0] next_addr
);
  localparam int PG_LG = vmem_pkg::PAGE_LG;
  localparam int PB_W  = PG_LG - BB_LG + 1;
  localparam int IX_W  = AW - BB_LG;

  logic [PB_W-1:0] to_page;
  logic [CW-1:0]   to_page_w;
  logic [CW-1:0]   cap_w;
  logic [CW-1:0]   pick;
  logic [IX_W-1:0] beat_idx;

  always_comb begin
    to_page   = PB_W'(1 << (PG_LG - BB_LG)) - {1'b0, cur_addr[PG_LG-1:BB_LG]};
    to_page_w = CW'(to_page);
    cap_w     = CW'(vmem_pkg::MAX_BURST);
    pick      = rem_beats;
    if (to_page_w < pick) pick = to_page_w;
    if (cap_w < pick)     pick = cap_w;
    beats     = pick;
    beat_idx  = cur_addr[AW-1:BB_LG] + IX_W'(pick);
    next_addr = {beat_idx, {BB_LG{1'b0}}};
  end
endmodule

// File: rtl/vmem_elem_addr.sv
`timescale 1ns/1ps
// Element address for single-beat modes and the running strided pointer.
module vmem_elem_addr #(
  parameter int AW = 32
) (
  input  logic          use_idx,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] stride,
  input  logic [AW-1:0] idx_off,
  output logic [AW-1:0] elem_addr,
  output logic [AW-1:0] step_addr
);
  always_comb begin
    elem_addr = use_idx ? (base + idx_off) : cur;
    step_addr = cur + stride;
  end
endmodule

// File: rtl/vmem_req_stage.sv
`timescale 1ns/1ps
// Registered request holder, steered to the load or the store port.
module vmem_req_stage #(
  parameter int AW     = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_store,
  input  logic [AW-1:0]     in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [SIZE_W-1:0] in_size,
  output logic              in_ready,
  output logic              hold,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [AW-1:0]     ld_addr,
  output logic [LEN_W-1:0]  ld_len,
  output logic [SIZE_W-1:0] ld_size,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [AW-1:0]     st_addr,
  output logic [LEN_W-1:0]  st_len,
  output logic [SIZE_W-1:0] st_size
);
  logic              vld_q, sto_q;
  logic [AW-1:0]     addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [SIZE_W-1:0] size_q;
  logic              accept;

  assign accept   = vld_q && (sto_q ? st_ready : ld_ready);
  assign in_ready = !vld_q || accept;
  assign hold     = vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      sto_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) sto_q <= in_store;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      addr_q <= in_addr;
      len_q  <= in_len;
      size_q <= in_size;
    end
  end

  assign ld_valid = vld_q && !sto_q;
  assign st_valid = vld_q && sto_q;
  assign ld_addr  = addr_q;
  assign st_addr  = addr_q;
  assign ld_len   = len_q;
  assign st_len   = len_q;
  assign ld_size  = size_q;
  assign st_size  = size_q;
endmodule

// File: rtl/vmem_addr_coalescer.sv
`timescale 1ns/1ps
module vmem_addr_coalescer
  import vmem_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LANES  = 2,
  parameter int MAX_VL = 1024,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [AW-1:0]        cmd_base,
  input  logic [1:0]           cmd_ew,
  input  logic [VL_W-1:0]      cmd_vl,
  input  logic [1:0]           cmd_mode,
  input  logic [AW-1:0]        cmd_stride,
  input  logic                 cmd_store,
  input  logic                 idx_valid,
  output logic                 idx_ready,
  input  logic [AW-1:0]        idx_off,
  output logic                 ld_valid,
  input  logic                 ld_ready,
  output logic [AW-1:0]        ld_addr,
  output logic [LEN_W-1:0]     ld_len,
  output logic [SIZE_W-1:0]    ld_size,
  output logic                 st_valid,
  input  logic                 st_ready,
  output logic [AW-1:0]        st_addr,
  output logic [LEN_W-1:0]     st_len,
  output logic [SIZE_W-1:0]    st_size
);
  localparam int BB     = 4 * LANES;          // bytes per beat
  localparam int BB_LG  = $clog2(BB);
  localparam int CW_RAW = $clog2(MAX_VL * 8 + BB) + 1;
  localparam int CW     = (CW_RAW > 13) ? CW_RAW : 13;

  logic              busy_q;
  amode_e            mode_q;
  logic              store_q;
  logic [1:0]        ew_q;
  logic [AW-1:0]     base_q, stride_q, cur_q;
  logic [VL_W-1:0]   rem_el_q;
  logic [CW-1:0]     rem_bt_q;

  logic [CW-1:0]     bytes_w, tot_beats;
  logic [CW-1:0]     burst_beats;
  logic [AW-1:0]     burst_next;
  logic [AW-1:0]     elem_addr, step_addr;
  logic              is_unit, is_idx;
  logic              gen_ok, issue, cmd_fire;
  logic              stg_ready, stg_hold;
  logic [AW-1:0]     req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [SIZE_W-1:0] req_size;

  assign is_unit  = (mode_q == AM_UNIT);
  assign is_idx   = (mode_q == AM_INDEX);
  assign gen_ok   = busy_q && (!is_idx || idx_valid);
  assign issue    = gen_ok && stg_ready;
  assign idx_ready = busy_q && is_idx && stg_ready;
  assign cmd_ready = !busy_q && !stg_hold;
  assign cmd_fire  = cmd_valid && cmd_ready;

  always_comb begin
    bytes_w   = CW'(cmd_vl) << cmd_ew;
    tot_beats = (CW'(cmd_base[BB_LG-1:0]) + bytes_w + CW'(BB - 1)) >> BB_LG;
  end

  vmem_burst_planner #(.AW(AW), .BB_LG(BB_LG), .CW(CW)) u_plan (
    .cur_addr  (cur_q),
    .rem_beats (rem_bt_q),
    .beats     (burst_beats),
    .next_addr (burst_next)
  );

  vmem_elem_addr #(.AW(AW)) u_elem (
    .use_idx   (is_idx),
    .base      (base_q),
    .cur       (cur_q),
    .stride    (stride_q),
    .idx_off   (idx_off),
    .elem_addr (elem_addr),
    .step_addr (step_addr)
  );

  always_comb begin
    if (is_unit) begin
      req_addr = cur_q;
      req_len  = LEN_W'(burst_beats - CW'(1));
      req_size = SIZE_W'(BB_LG);
    end else begin
      req_addr = elem_addr;
      req_len  = '0;
      req_size = SIZE_W'(ew_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      mode_q   <= AM_UNIT;
      store_q  <= 1'b0;
      ew_q     <= '0;
      base_q   <= '0;
      stride_q <= '0;
      cur_q    <= '0;
      rem_el_q <= '0;
      rem_bt_q <= '0;
    end else if (cmd_fire) begin
      busy_q   <= (cmd_vl != '0);
      mode_q   <= cmd_mode[1] ? AM_INDEX : amode_e'(cmd_mode);
      store_q  <= cmd_store;
      ew_q     <= cmd_ew;
      base_q   <= cmd_base;
      stride_q <= cmd_stride;
      cur_q    <= cmd_base;
      rem_el_q <= cmd_vl;
      rem_bt_q <= tot_beats;
    end else if (issue) begin
      if (is_unit) begin
        cur_q    <= burst_next;
        rem_bt_q <= rem_bt_q - burst_beats;
        if (rem_bt_q == burst_beats) busy_q <= 1'b0;
      end else begin
        cur_q    <= step_addr;
        rem_el_q <= rem_el_q - VL_W'(1);
        if (rem_el_q == VL_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  vmem_req_stage #(.AW(AW), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (gen_ok),
    .in_store (store_q),
    .in_addr  (req_addr),
    .in_len   (req_len),
    .in_size  (req_size),
    .in_ready (stg_ready),
    .hold     (stg_hold),
    .ld_valid (ld_valid),
    .ld_ready (ld_ready),
    .ld_addr  (ld_addr),
    .ld_len   (ld_len),
    .ld_size  (ld_size),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .st_addr  (st_addr),
    .st_len   (st_len),
    .st_size  (st_size)
  );
endmodule

// File: rtl/vmem_addr_coalescer_chk.sv
`timescale 1ns/1ps
module vmem_addr_coalescer_chk #(
  parameter int AW    = 32,
  parameter int LANES = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_ready,
  input logic          idx_ready,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic [AW-1:0] ld_addr,
  input logic [7:0]    ld_len,
  input logic [2:0]    ld_size,
  input logic          st_valid,
  input logic          st_ready,
  input logic [AW-1:0] st_addr,
  input logic [7:0]    st_len,
  input logic [2:0]    st_size
);
  localparam int BB_LG = $clog2(4 * LANES);

  logic [13:0] ld_end, st_end;
  always_comb begin
    ld_end = 14'({ld_addr[11:BB_LG], {BB_LG{1'b0}}}) + ((14'(ld_len) + 14'd1) << BB_LG);
    st_end = 14'({st_addr[11:BB_LG], {BB_LG{1'b0}}}) + ((14'(st_len) + 14'd1) << BB_LG);
  end

  assert_ld_page_R2: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> ld_end <= 14'd4096);
  assert_st_page_R2: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> st_end <= 14'd4096);
  assert_ld_single_R4: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_size != 3'(BB_LG)) |-> ld_len == 8'd0);
  assert_st_single_R4: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_size != 3'(BB_LG)) |-> st_len == 8'd0);
  assert_idx_busy_R5: assert property (@(posedge clk) disable iff (rst)
    idx_ready |-> !cmd_ready);
  assert_one_port_R6: assert property (@(posedge clk) disable iff (rst)
    !(ld_valid && st_valid));
  assert_ld_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_addr) && $stable(ld_len) && $stable(ld_size)));
  assert_st_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_len) && $stable(st_size)));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!ld_valid && !st_valid));
endmodule

bind vmem_addr_coalescer vmem_addr_coalescer_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .idx_ready(idx_ready),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_len(ld_len), .ld_size(ld_size),
  .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_len(st_len), .st_size(st_size)
);

// File: tb/vmem_addr_coalescer_bench.sv
`timescale 1ns/1ps
module vmem_addr_coalescer_bench;
  localparam int AW = 32;
  localparam int LANES = 2;
  localparam int MAX_VL = 1024;
  localparam int VL_W = $clog2(MAX_VL + 1);
  localparam int BB = 4 * LANES;
  localparam int BB_LG = $clog2(BB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready, cmd_store = 1'b0;
  logic [AW-1:0] cmd_base = '0, cmd_stride = '0;
  logic [1:0] cmd_ew = '0, cmd_mode = '0;
  logic [VL_W-1:0] cmd_vl = '0;
  logic idx_valid = 1'b0, idx_ready;
  logic [AW-1:0] idx_off = '0;
  logic ld_valid, st_valid;
  logic ld_ready = 1'b0, st_ready = 1'b0;
  logic [AW-1:0] ld_addr, st_addr;
  logic [7:0] ld_len, st_len;
  logic [2:0] ld_size, st_size;

  always #2.5 clk = ~clk;

  vmem_addr_coalescer #(.AW(AW), .LANES(LANES), .MAX_VL(MAX_VL)) u_vmem_addr_coalescer (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_ew(cmd_ew), .cmd_vl(cmd_vl), .cmd_mode(cmd_mode),
    .cmd_stride(cmd_stride), .cmd_store(cmd_store),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_off(idx_off),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_len(ld_len), .ld_size(ld_size),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_len(st_len), .st_size(st_size)
  );

  int n_chk = 0;
  int n_fail = 0;
  int beats_seen = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [AW-1:0] exp_addr[$];
  int            exp_len[$];
  int            exp_size[$];
  bit            exp_st[$];
  string         exp_tag[$];
  logic [AW-1:0] idx_q[$];

  bit            idx_hs_pend = 1'b0;
  bit            prev_stall = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [7:0]    prev_len;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push_exp(input logic [AW-1:0] a, input int l, input int s, input bit st, input string tag);
    exp_addr.push_back(a); exp_len.push_back(l); exp_size.push_back(s);
    exp_st.push_back(st); exp_tag.push_back(tag);
  endtask

  // Output monitor, engine readiness and offset-stream driver.
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic          v;
      logic [AW-1:0] a;
      logic [7:0]    l;
      logic [2:0]    s;
      bit            hs;
      if (idx_hs_pend && idx_q.size() > 0) void'(idx_q.pop_front());
      v = ld_valid || st_valid;
      a = st_valid ? st_addr : ld_addr;
      l = st_valid ? st_len : ld_len;
      s = st_valid ? st_size : ld_size;
      chk(!(ld_valid && st_valid), "R6 both ports valid", 1, 0);
      if (prev_stall)
        chk(v && a == prev_addr && l == prev_len, "R7 stalled request changed", a, prev_addr);
      if (v) begin
        if (exp_addr.size() == 0) chk(1'b0, "R8 request with none expected", a, 0);
        else begin
          chk(st_valid == exp_st[0], {exp_tag[0], " R6 port"}, st_valid, exp_st[0]);
          chk(a == exp_addr[0], {exp_tag[0], " addr"}, a, exp_addr[0]);
          chk(int'(l) == exp_len[0], {exp_tag[0], " len"}, l, exp_len[0]);
          chk(int'(s) == exp_size[0], {exp_tag[0], " size"}, s, exp_size[0]);
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ld_ready = bp_on ? lfsr[0] : 1'b1;
      st_ready = bp_on ? lfsr[3] : 1'b1;
      hs = v && (st_valid ? st_ready : ld_ready);
      prev_stall = v && !hs;
      prev_addr = a;
      prev_len = l;
      if (hs) begin
        beats_seen += int'(l) + 1;
        if (exp_addr.size() > 0) begin
          void'(exp_addr.pop_front()); void'(exp_len.pop_front()); void'(exp_size.pop_front());
          void'(exp_st.pop_front()); void'(exp_tag.pop_front());
        end
      end
      idx_valid = (idx_q.size() > 0) && (bp_on ? lfsr[5] : 1'b1);
      idx_off = (idx_q.size() > 0) ? idx_q[0] : '0;
      #1;
      idx_hs_pend = idx_valid && idx_ready;
    end
  end

  task automatic run_cmd(input int mode, input logic [AW-1:0] base, input int ew, input int vl,
                         input logic [AW-1:0] stride, input bit st, input string tag);
    int start_beats;
    int cov;
    if (mode == 0) begin
      longint a, endb, ba, pe, lim, nb;
      a = base; endb = longint'(base) + (longint'(vl) << ew);
      while (a < endb) begin
        ba = a & ~longint'(BB - 1);
        pe = (ba | 4095) + 1;
        lim = endb;
        if (pe < lim) lim = pe;
        if (ba + 256 * BB < lim) lim = ba + 256 * BB;
        nb = (lim - ba + BB - 1) / BB;
        push_exp(a[AW-1:0], int'(nb) - 1, BB_LG, st, tag);
        a = ba + nb * BB;
      end
      cov = (vl == 0) ? 0 : int'(((longint'(base) + (longint'(vl) << ew) - 1) >> BB_LG) - (longint'(base) >> BB_LG) + 1);
    end else if (mode == 1) begin
      for (int i = 0; i < vl; i++) push_exp(base + stride * i, 0, ew, st, tag);
      cov = vl;
    end else begin
      for (int i = 0; i < vl; i++) push_exp(base + idx_q[i], 0, ew, st, tag);
      cov = vl;
    end
    start_beats = beats_seen;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_base = base; cmd_ew = 2'(ew); cmd_vl = VL_W'(vl);
    cmd_mode = 2'(mode); cmd_stride = stride; cmd_store = st;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 20000 && (exp_addr.size() > 0 || !cmd_ready); k++) @(negedge clk);
    chk(exp_addr.size() == 0, {tag, " all requests seen"}, exp_addr.size(), 0);
    chk(beats_seen - start_beats == cov, {tag, " R1 beat coverage"}, beats_seen - start_beats, cov);
    chk(cmd_ready == 1'b1, {tag, " R8 ready after drain"}, cmd_ready, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 cmd_ready after reset", cmd_ready, 1);
    chk(!ld_valid && !st_valid, "R9 ports idle in reset", {ld_valid, st_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && !ld_valid && !st_valid, "R9 idle after reset", cmd_ready, 1);

    // Unit stride: aligned, unaligned, page edge, burst cap
    run_cmd(0, 32'h0000_0100, 3, 8,    0, 1'b0, "R1 aligned");
    run_cmd(0, 32'h0000_1003, 0, 40,   0, 1'b1, "R1 unaligned");
    run_cmd(0, 32'h0000_0FFC, 2, 4,    0, 1'b0, "R2 page edge");
    bp_on = 1'b1;
    run_cmd(0, 32'h0000_3000, 3, 600,  0, 1'b1, "R3 cap split");
    run_cmd(0, 32'h0000_07F0, 1, 1023, 0, 1'b0, "R2 long run");
    // Strided
    bp_on = 1'b0;
    run_cmd(1, 32'h0000_0500, 3, 5, 32'd24,         1'b0, "R4 pos stride");
    bp_on = 1'b1;
    run_cmd(1, 32'h0000_2000, 2, 6, 32'hFFFF_FFF8,  1'b1, "R4 neg stride");
    run_cmd(1, 32'h0000_0040, 1, 3, 32'd0,          1'b0, "R4 zero stride");
    // Indexed
    idx_q = '{32'h10, 32'h4, 32'h800, 32'h0, 32'h1234, 32'h8};
    run_cmd(2, 32'h0001_0000, 2, 6, 0, 1'b0, "R5 gather");
    chk(idx_q.size() == 0, "R5 offsets consumed", idx_q.size(), 0);
    idx_q = '{32'h20, 32'h0, 32'hFFFF_FFF0, 32'h40};
    run_cmd(3, 32'h0000_9000, 3, 4, 0, 1'b1, "R5 scatter");
    chk(idx_q.size() == 0, "R5 scatter offsets consumed", idx_q.size(), 0);
    // Zero length
    bp_on = 1'b0;
    run_cmd(0, 32'h0000_0200, 3, 0, 0, 1'b0, "R8 zero vl");
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!ld_valid && !st_valid, "R8 no request for vl 0", {ld_valid, st_valid}, 0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule